// File: doc/BRIEF.md
# Debug Memory Access Controller

This block sits between a debug transport and the rest of the chip. It lets an external debug host read and write the CPU register file and the 16-bit memory space, which holds RAM, ROM, the interrupt vector area and memory-mapped peripherals. The host sees three registers: an address register, a data register and a control register. Writing the control register with its start bit set runs exactly one access.

The engine decodes the control bits and picks one of two targets. It drives either a register-file port or a memory bus master port. It raises the request and holds it until the target grants. Write data is steered onto byte lanes, and read data is captured back into the data register one cycle after the read is granted. Byte reads come back zero-extended.

The serial framing that carries host commands sits outside this block. The host always loads the address and data registers before it writes the control register.

Top module: `dbg_mem_engine`

## Requirements
- R1: After reset the address, data and control registers read back as zero, `busy` is low and neither `mb_req` nor `rf_req` is asserted.
- R2: Host register select values are 0 for address, 1 for data and 2 for control; select 3 reads as zero. The control register's low four bits are bit0 start, bit1 write, bit2 register target and bit3 byte mode. It reads back as the value written, except that the start bit clears when the access completes.
- R3: A word memory read (control 0x0001) requests address bits [15:1] on `mb_addr` with `mb_be`=2'b11. It loads `mb_rdata`, as sampled one cycle after the grant, into the data register.
- R4: A word memory write (control 0x0003) drives the full data register on `mb_wdata` with `mb_be`=2'b11.
- R5: A byte memory read (control 0x0009) uses `mb_be`=2'b01 for an even address and 2'b10 for an odd address. It returns the addressed byte (low byte for even, high byte for odd) zero-extended in the data register.
- R6: A byte memory write (control 0x000B) places data bits [7:0] on both lanes of `mb_wdata` and enables only the addressed lane, so the other byte of the target word is left unchanged.
- R7: Register accesses (control 0x0005 read, 0x0007 write) use address bits [3:0] as `rf_idx` and always transfer all 16 bits. The byte-mode bit has no effect on them.
- R8: Only one of `mb_req` and `rf_req` is ever asserted. A request stays asserted, with stable address, enables and write data, until its grant is seen.
- R9: `busy` is high from the cycle after an accepted start until the access completes. Any host register write issued while `busy` is high is ignored.
- R10: A control write with bit0 clear starts no access and only stores the control bits.
- R11: With the grant held high, a write completes (busy low) one cycle after the start is accepted and a read completes two cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_wr_sel | input | 2 | Host register selected for write |
| hst_wr_data | input | 16 | Host write value |
| hst_rd_sel | input | 2 | Host register selected for read |
| hst_rd_data | output | 16 | Read-back of the selected host register |
| busy | output | 1 | Access in progress |
| rf_req | output | 1 | Register-file access request |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 4 | Register index |
| rf_wdata | output | 16 | Register write data |
| rf_gnt | input | 1 | Register-file grant |
| rf_rdata | input | 16 | Register read data, valid the cycle after grant |
| mb_req | output | 1 | Memory bus request |
| mb_we | output | 1 | Memory bus write enable |
| mb_addr | output | 15 | Memory word address |
| mb_be | output | 2 | Byte lane enables |
| mb_wdata | output | 16 | Memory write data |
| mb_gnt | input | 1 | Memory bus grant |
| mb_rdata | input | 16 | Memory read data, valid the cycle after grant |

## Verification
Each of the six command kinds is tried: word read, word write, byte read and byte write to memory, and register read and write. They are issued in random order, with random addresses and random data, against grants that come late at random. Even and odd byte addresses tell apart the lane choice in both directions. Reading back the full target word after a byte write separates a correct single-lane update from a write that spills onto both lanes. Directed cases cover the rest: a control write without start, host writes made while the grant is held off (these must not retarget or restart the access), register accesses with the byte bit set, and the completion latency with an immediate grant.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef struct packed {
    logic byte_m;
    logic reg_m;
    logic wr;
    logic start;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_CAP = 2'd2} seq_st_e;

  // Lane enable for lane g given mode and address parity.
  function automatic logic lane_on(input logic byte_m, input logic odd, input int g);
    if (!byte_m) return 1'b1;
    return (g == (odd ? 1 : 0));
  endfunction

  // Byte shown on lane g for a write.
  function automatic logic [BYTE_W-1:0] lane_wbyte(input logic byte_m,
                                                   input logic [DATA_W-1:0] d, input int g);
    if (byte_m) return d[BYTE_W-1:0];
    return d[g*BYTE_W +: BYTE_W];
  endfunction

  // Read value returned to the data register.
  function automatic logic [DATA_W-1:0] rd_extract(input logic byte_m, input logic odd,
                                                   input logic [DATA_W-1:0] r);
    logic [DATA_W-1:0] v;
    v = '0;
    if (!byte_m) v = r;
    else if (odd) v[BYTE_W-1:0] = r[2*BYTE_W-1:BYTE_W];
    else          v[BYTE_W-1:0] = r[BYTE_W-1:0];
    return v;
  endfunction
endpackage

// File: rtl/dbg_host_regs.sv
module dbg_host_regs
  import dbg_mem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output ctrl_t             ctrl_o,
  output logic              start_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  ctrl_t             ctrl_q;
  logic              wr_ok;

  assign wr_ok   = wr_en && !busy_i;
  assign start_o = wr_ok && (wr_sel == SEL_CTRL) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_ok && wr_sel == SEL_ADDR) addr_q <= wr_data[ADDR_W-1:0];
      if (cap_en_i) data_q <= cap_data_i;
      else if (wr_ok && wr_sel == SEL_DATA) data_q <= wr_data;
      if (wr_ok && wr_sel == SEL_CTRL) ctrl_q <= ctrl_t'(wr_data[3:0]);
      else if (done_i) ctrl_q.start <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_ADDR: rd_data[ADDR_W-1:0] = addr_q;
      SEL_DATA: rd_data = data_q;
      SEL_CTRL: rd_data[3:0] = ctrl_q;
      default:  rd_data = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign ctrl_o = ctrl_q;

  // R2/R9: stored start bit mirrors the sequencer's busy state
  assert_start_tracks_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.start == busy_i);
  // R9: address cannot be changed by the host during an access
  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(addr_q));
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_mem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic is_reg_i,
  input  logic is_wr_i,
  input  logic mb_gnt_i,
  input  logic rf_gnt_i,
  output logic mb_req_o,
  output logic rf_req_o,
  output logic cap_en_o,
  output logic done_o,
  output logic busy_o
);
  seq_st_e st_q, st_d;
  logic    gnt_sel;
  logic    accept;

  assign gnt_sel = is_reg_i ? rf_gnt_i : mb_gnt_i;
  assign accept  = (st_q == ST_REQ) && gnt_sel;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_REQ;
      ST_REQ:  if (gnt_sel) st_d = is_wr_i ? ST_IDLE : ST_CAP;
      ST_CAP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign mb_req_o = (st_q == ST_REQ) && !is_reg_i;
  assign rf_req_o = (st_q == ST_REQ) &&  is_reg_i;
  assign cap_en_o = (st_q == ST_CAP);
  assign done_o   = (accept && is_wr_i) || (st_q == ST_CAP);
  assign busy_o   = (st_q != ST_IDLE);

  // R8: the two targets are never requested together
  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_req_o && rf_req_o));
  // R8: an ungranted memory request stays up
  assert_mb_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req_o && !mb_gnt_i) |=> mb_req_o);
  // R8: an ungranted register request stays up
  assert_rf_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_o && !rf_gnt_i) |=> rf_req_o);
  // R3: capture happens exactly one cycle after a granted read
  assert_cap_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_o |-> $past(accept && !is_wr_i));
  // R9: busy only rises after a start command
  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/dbg_lane.sv
module dbg_lane
  import dbg_mem_pkg::*;
(
  input  logic              byte_m,
  input  logic              is_reg,
  input  logic              odd,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mb_rdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] cap_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_o[g]                   = lane_on(byte_m, odd, g);
    assign wdata_o[g*BYTE_W +: BYTE_W] = lane_wbyte(byte_m, data_i, g);
  end

  assign cap_o = is_reg ? rf_rdata : rd_extract(byte_m, odd, mb_rdata);
endmodule

// File: rtl/dbg_mem_engine.sv
module dbg_mem_engine
  import dbg_mem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr_en,
  input  logic [1:0]        hst_wr_sel,
  input  logic [15:0]       hst_wr_data,
  input  logic [1:0]        hst_rd_sel,
  output logic [15:0]       hst_rd_data,
  output logic              busy,
  output logic              rf_req,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_idx,
  output logic [15:0]       rf_wdata,
  input  logic              rf_gnt,
  input  logic [15:0]       rf_rdata,
  output logic              mb_req,
  output logic              mb_we,
  output logic [ADDR_W-2:0] mb_addr,
  output logic [1:0]        mb_be,
  output logic [15:0]       mb_wdata,
  input  logic              mb_gnt,
  input  logic [15:0]       mb_rdata
);
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] data_w;
  logic [DATA_W-1:0] cap_w;
  ctrl_t             ctrl_w;
  logic              start_w;
  logic              done_w;
  logic              cap_en_w;

  dbg_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (hst_wr_en),
    .wr_sel     (hst_wr_sel),
    .wr_data    (hst_wr_data),
    .rd_sel     (hst_rd_sel),
    .rd_data    (hst_rd_data),
    .busy_i     (busy),
    .done_i     (done_w),
    .cap_en_i   (cap_en_w),
    .cap_data_i (cap_w),
    .addr_o     (addr_w),
    .data_o     (data_w),
    .ctrl_o     (ctrl_w),
    .start_o    (start_w)
  );

  dbg_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_w),
    .is_reg_i (ctrl_w.reg_m),
    .is_wr_i  (ctrl_w.wr),
    .mb_gnt_i (mb_gnt),
    .rf_gnt_i (rf_gnt),
    .mb_req_o (mb_req),
    .rf_req_o (rf_req),
    .cap_en_o (cap_en_w),
    .done_o   (done_w),
    .busy_o   (busy)
  );

  dbg_lane u_lane (
    .byte_m   (ctrl_w.byte_m),
    .is_reg   (ctrl_w.reg_m),
    .odd      (addr_w[0]),
    .data_i   (data_w),
    .mb_rdata (mb_rdata),
    .rf_rdata (rf_rdata),
    .be_o     (mb_be),
    .wdata_o  (mb_wdata),
    .cap_o    (cap_w)
  );

  assign mb_addr  = addr_w[ADDR_W-1:1];
  assign mb_we    = ctrl_w.wr;
  assign rf_we    = ctrl_w.wr;
  assign rf_idx   = addr_w[RIDX_W-1:0];
  assign rf_wdata = data_w;

  // R4: word accesses enable both lanes
  assert_word_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && !ctrl_w.byte_m) |-> (mb_be == 2'b11));
  // R5: byte accesses enable exactly one lane
  assert_byte_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && ctrl_w.byte_m) |-> ($countones(mb_be) == 1));
  // R6: byte write data is replicated on both lanes
  assert_byte_repl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && mb_we && ctrl_w.byte_m) |-> (mb_wdata[15:8] == mb_wdata[7:0]));
  // R8: request attributes stay put while waiting for the grant
  assert_attr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && !mb_gnt) |=> ($stable(mb_addr) && $stable(mb_be) && $stable(mb_wdata)));
endmodule

// File: tb/test_dbg_mem_engine.sv
`timescale 1ns/100ps
module test_dbg_mem_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr_en = 1'b0;
  logic [1:0]  hst_wr_sel = 2'd0;
  logic [15:0] hst_wr_data = 16'd0;
  logic [1:0]  hst_rd_sel = 2'd0;
  logic [15:0] hst_rd_data;
  logic        busy, rf_req, rf_we, rf_gnt, mb_req, mb_we, mb_gnt;
  logic [3:0]  rf_idx;
  logic [15:0] rf_wdata, mb_wdata;
  logic [15:0] rf_rdata, mb_rdata;
  logic [14:0] mb_addr;
  logic [1:0]  mb_be;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit gnt_hold = 1'b0, gnt_force = 1'b0;
  logic [15:0] mem [256];
  logic [15:0] rfm [16];
  logic [15:0] mirror [256];
  logic [15:0] rmirror [16];

  always #2.5 clk = ~clk;

  dbg_mem_engine i_dbg_mem_engine (
    .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_wr_sel(hst_wr_sel),
    .hst_wr_data(hst_wr_data), .hst_rd_sel(hst_rd_sel), .hst_rd_data(hst_rd_data),
    .busy(busy), .rf_req(rf_req), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .rf_gnt(rf_gnt), .rf_rdata(rf_rdata), .mb_req(mb_req), .mb_we(mb_we),
    .mb_addr(mb_addr), .mb_be(mb_be), .mb_wdata(mb_wdata), .mb_gnt(mb_gnt),
    .mb_rdata(mb_rdata));

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 16'h3b1) ^ 16'h5a5a;
  endfunction

  // Slave models: act on request and grant, read data valid next cycle.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      for (int i = 0; i < 16; i++) rfm[i] <= init_word(i + 300);
      mb_rdata <= 16'h0;
      rf_rdata <= 16'h0;
    end else begin
      if (mb_req && mb_gnt) begin
        if (mb_we) begin
          if (mb_be[0]) mem[mb_addr[7:0]][7:0]  <= mb_wdata[7:0];
          if (mb_be[1]) mem[mb_addr[7:0]][15:8] <= mb_wdata[15:8];
        end else mb_rdata <= mem[mb_addr[7:0]];
      end
      if (rf_req && rf_gnt) begin
        if (rf_we) rfm[rf_idx] <= rf_wdata;
        else       rf_rdata <= rfm[rf_idx];
      end
    end
  end

  initial begin
    mb_gnt = 1'b0;
    rf_gnt = 1'b0;
    forever begin
      @(negedge clk);
      if (gnt_hold)       begin mb_gnt = 1'b0; rf_gnt = 1'b0; end
      else if (gnt_force) begin mb_gnt = 1'b1; rf_gnt = 1'b1; end
      else begin
        mb_gnt = ($urandom % 3) != 0;
        rf_gnt = ($urandom % 3) != 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_wr_sel = s; hst_wr_data = v;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hr(input logic [1:0] s, output logic [15:0] v);
    hst_rd_sel = s;
    #1;
    v = hst_rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  // Bench-side expectations
  function automatic logic [15:0] exp_byte_rd(input logic [15:0] w, input logic odd);
    return odd ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction
  function automatic logic [15:0] exp_byte_wr(input logic [15:0] w, input logic odd,
                                              input logic [7:0] b);
    return odd ? {b, w[7:0]} : {w[15:8], b};
  endfunction

  task automatic run_op(input int kind, input logic [15:0] a, input logic [15:0] d);
    logic [15:0] v, c;
    logic [7:0] wi;
    wi = a[8:1];
    hw(2'd0, a);
    hw(2'd1, d);
    case (kind)
      0: c = 16'h0001; 1: c = 16'h0003; 2: c = 16'h0009;
      3: c = 16'h000B; 4: c = 16'h0005; default: c = 16'h0007;
    endcase
    hw(2'd2, c);
    wait_idle();
    hr(2'd2, v);
    chk("R2 ctrl readback after completion", v, c & 16'h000E);
    case (kind)
      0: begin hr(2'd1, v); chk("R3 word read", v, mirror[wi]); end
      1: begin mirror[wi] = d; chk("R4 word write", mem[wi], mirror[wi]); end
      2: begin hr(2'd1, v); chk("R5 byte read", v, exp_byte_rd(mirror[wi], a[0])); end
      3: begin
           mirror[wi] = exp_byte_wr(mirror[wi], a[0], d[7:0]);
           chk("R6 byte write", mem[wi], mirror[wi]);
         end
      4: begin hr(2'd1, v); chk("R7 register read", v, rmirror[a[3:0]]); end
      default: begin
           rmirror[a[3:0]] = d;
           chk("R7 register write", rfm[a[3:0]], rmirror[a[3:0]]);
         end
    endcase
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd424242));
    for (int i = 0; i < 256; i++) mirror[i] = init_word(i);
    for (int i = 0; i < 16; i++) rmirror[i] = init_word(i + 300);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hr(2'd0, v); chk("R1 addr reset", v, 16'h0);
    hr(2'd1, v); chk("R1 data reset", v, 16'h0);
    hr(2'd2, v); chk("R1 ctrl reset", v, 16'h0);
    chk("R1 busy/req reset", {13'd0, busy, mb_req, rf_req}, 16'h0);

    // R2 select 3 reads zero
    hw(2'd0, 16'h1234);
    hr(2'd3, v); chk("R2 unused select", v, 16'h0);

    // R10 control without start
    hw(2'd2, 16'h000A);
    chk("R10 no access started", {14'd0, busy, mb_req}, 16'h0);
    @(negedge clk);
    chk("R10 still idle", {15'd0, busy}, 16'h0);
    hr(2'd2, v); chk("R10 ctrl bits stored", v, 16'h000A);

    // R11 latency with immediate grant
    gnt_force = 1'b1;
    @(negedge clk);
    hw(2'd0, 16'h0040);
    hw(2'd1, 16'hbeef);
    hw(2'd2, 16'h0003);
    chk("R11 write busy after start", {15'd0, busy}, 16'h1);
    @(negedge clk);
    chk("R11 write done after one cycle", {15'd0, busy}, 16'h0);
    mirror[8'h20] = 16'hbeef;
    chk("R4 directed word write", mem[8'h20], 16'hbeef);
    hw(2'd2, 16'h0001);
    chk("R11 read busy in request", {15'd0, busy}, 16'h1);
    @(negedge clk);
    chk("R11 read busy in capture", {15'd0, busy}, 16'h1);
    @(negedge clk);
    chk("R11 read done after two cycles", {15'd0, busy}, 16'h0);
    hr(2'd1, v); chk("R3 directed word read", v, 16'hbeef);
    gnt_force = 1'b0;

    // R5 directed odd/even byte reads
    hw(2'd0, 16'h0041); hw(2'd2, 16'h0009); wait_idle();
    hr(2'd1, v); chk("R5 odd byte read", v, 16'h00be);
    hw(2'd0, 16'h0040); hw(2'd2, 16'h0009); wait_idle();
    hr(2'd1, v); chk("R5 even byte read", v, 16'h00ef);

    // R6 directed odd byte write
    hw(2'd0, 16'h0041); hw(2'd1, 16'h25c4); hw(2'd2, 16'h000B); wait_idle();
    mirror[8'h20] = 16'hc4ef;
    chk("R6 odd byte write keeps low byte", mem[8'h20], 16'hc4ef);

    // R7 byte bit ignored on register access
    hw(2'd0, 16'h0005); hw(2'd1, 16'hed32); hw(2'd2, 16'h000F); wait_idle();
    rmirror[5] = 16'hed32;
    chk("R7 register write ignores byte bit", rfm[5], 16'hed32);
    hw(2'd2, 16'h000D); wait_idle();
    hr(2'd1, v); chk("R7 register read ignores byte bit", v, 16'hed32);

    // R8/R9 host writes during a stalled access
    gnt_hold = 1'b1;
    @(negedge clk);
    hw(2'd0, 16'h0010);
    hw(2'd2, 16'h0001);
    hw(2'd0, 16'h0088);
    hw(2'd1, 16'h7777);
    hw(2'd2, 16'h0007);
    chk("R8 memory request held, no register request",
        {14'd0, mb_req, rf_req}, 16'h2);
    chk("R9 busy while stalled", {15'd0, busy}, 16'h1);
    hr(2'd0, v); chk("R9 addr write ignored while busy", v, 16'h0010);
    hr(2'd2, v); chk("R9 ctrl write ignored while busy", v, 16'h0001);
    chk("R8 stalled address", {1'b0, mb_addr}, 16'h0008);
    gnt_hold = 1'b0;
    wait_idle();
    hr(2'd1, v); chk("R9 original read completes", v, mirror[8'h08]);

    // Random mix
    for (int n = 0; n < 160; n++) begin
      int k;
      logic [15:0] a, d;
      k = int'($urandom % 6);
      a = 16'($urandom % 512);
      d = 16'($urandom);
      run_op(k, a, d);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule